// File: doc/BRIEF.md
# Filtered Error Manager with Auto-Stop

This block watches a stream of error events. Each event has a 6-bit source and an 8-bit code. Eight programmable filter entries each name one source/code pair and a set of actions. An accepted event that matches an enabled entry can do any mix of four things: bump a saturating 16-bit error counter, set that entry's bit in an 8-bit flag register, request a notification, or halt the manager. A control register gives software separate self-clearing clears for the flags and the counter, a sticky halt bit and a notification enable. A capability register lets the hardware halt the manager on its own when every flag is set or when the counter climbs to a threshold. Both auto-halts also raise a notification.

A notification is one 64-bit word. It is sent with a programmable destination ID over a valid/ready handshake. The word carries the event's source and code with the flag and counter values as they stand after the event. While the manager is halted, incoming events are dropped.

Top module: `fault_mgr`

## Requirements
- R1: An event with `ev_valid` high is accepted when the manager is not halted. It matches entry i (address i, 0..7) when the entry's enable bit 14 is set, its bits [5:0] equal the source and its bits [13:6] equal the code. A match on an entry with count bit 15 increments the counter by one in the next cycle. Non-matching events and disabled entries change nothing.
- R2: The counter (address 12, bits [15:0]) saturates at 0xFFFF and stays there until it is cleared.
- R3: Writing the control register (address 8) with bit 0 set clears the flags, and with bit 1 set clears the counter. Both bits read back as 0. A clear takes priority over an update from an event in the same cycle.
- R4: Control bit 2 is the halt bit. Writing 1 halts the manager, and it stays halted until software writes 0 to the bit.
- R5: A match on an entry with stop bit 18 sets the halt bit.
- R6: While halted, the flags, the counter and the notification output do not change in response to events.
- R7: With capability bit 0 set (address 9), an event that leaves all 8 flags set also sets the halt bit and requests a notification.
- R8: With capability bit 1 set, an increment that brings the counter to exactly 0x00FF sets the halt bit and requests a notification.
- R9: A notification is requested only when a matched entry has notify bit 17 set, or when an auto-halt (R7 or R8) fires. It is issued only while control bit 3 is set. The word is {source, code, flags, counter, 26 zero bits}, MSB first. `ntf_dest` carries the value written to address 10.
- R10: `ntf_valid` and `ntf_data` hold until `ntf_ready` is sampled high. A request that arrives while a word is pending is dropped, but its flag and counter updates still take place.
- R11: A match on entry i with flag bit 16 sets flag bit i (address 11, bits [7:0]). Flags stay set until they are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Error event present this cycle |
| ev_src | input | 6 | Event source |
| ev_code | input | 8 | Event code |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ntf_valid | output | 1 | Notification word pending |
| ntf_ready | input | 1 | Receiver takes the word |
| ntf_data | output | 64 | Notification word |
| ntf_dest | output | 16 | Notification destination ID |

## Verification
Every cycle, the assertions check the following:
- the counter moves by at most one step and stays pinned at its ceiling;
- flags only gain bits unless software writes a register;
- a halted manager holds its flags, counter and halt bit, and starts no notification;
- a pending notification stays stable with its zero padding.

Some behaviour depends on programmed filters and exact payload values, and only the bench scenarios can show it:
- which entry and which action bit respond to which source/code pair;
- the two auto-halt conditions firing on the exact triggering event;
- notifications that are dropped while the enable is off or while a word is pending;
- clears winning over same-cycle events.

// File: rtl/fault_mgr_pkg.sv
package fault_mgr_pkg;
  localparam int unsigned SRC_W  = 6;
  localparam int unsigned CODE_W = 8;
  localparam int unsigned N_ENT  = 8;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;

  // Register addresses (entries occupy 0..N_ENT-1)
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd8;
  localparam logic [ADDR_W-1:0] A_CAP   = 4'd9;
  localparam logic [ADDR_W-1:0] A_DEST  = 4'd10;
  localparam logic [ADDR_W-1:0] A_FLAGS = 4'd11;
  localparam logic [ADDR_W-1:0] A_CNT   = 4'd12;

  // Control register bit positions
  localparam int unsigned C_FCLR = 0;
  localparam int unsigned C_CCLR = 1;
  localparam int unsigned C_STOP = 2;
  localparam int unsigned C_NTEN = 3;

  // Filter entry, LSB first: src, code, en, count, flag, notify, stop
  typedef struct packed {
    logic              stop;
    logic              notify;
    logic              flag;
    logic              count;
    logic              en;
    logic [CODE_W-1:0] code;
    logic [SRC_W-1:0]  src;
  } filt_t;

  localparam int unsigned FILT_W = $bits(filt_t);
endpackage

// File: rtl/fault_mgr_match.sv
module fault_mgr_match
  import fault_mgr_pkg::*;
(
  input  filt_t [N_ENT-1:0] ent,
  input  logic [SRC_W-1:0]  src,
  input  logic [CODE_W-1:0] code,
  output logic [N_ENT-1:0]  hit
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign hit[g] = ent[g].en && (ent[g].src == src) && (ent[g].code == code);
  end
endmodule

// File: rtl/fault_mgr_cnt.sv
module fault_mgr_cnt #(
  parameter int unsigned       CNT_W  = 16,
  parameter logic [CNT_W-1:0]  THRESH = 'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             reach
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cnt_nxt = cnt_q;
    reach   = 1'b0;
    if (clr) begin
      cnt_nxt = '0;
    end else if (inc && (cnt_q != MAXV)) begin
      cnt_nxt = cnt_q + 1'b1;
      reach   = (cnt_nxt == THRESH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/fault_mgr_ntf.sv
module fault_mgr_ntf #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);
  logic         vld_q, vld_d;
  logic [W-1:0] dat_q, dat_d;
  logic         take;

  always_comb begin
    take  = load && (!vld_q || ready);
    vld_d = take || (vld_q && !ready);
    dat_d = take ? word : dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (take) dat_q <= dat_d;
    end
  end

  assign valid = vld_q;
  assign data  = dat_q;
endmodule

// File: rtl/fault_mgr.sv
module fault_mgr
  import fault_mgr_pkg::*;
#(
  parameter int unsigned      CNT_W  = 16,
  parameter int unsigned      DEST_W = 16,
  parameter logic [CNT_W-1:0] THRESH = 'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [SRC_W-1:0]  ev_src,
  input  logic [CODE_W-1:0] ev_code,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              ntf_valid,
  input  logic              ntf_ready,
  output logic [63:0]       ntf_data,
  output logic [DEST_W-1:0] ntf_dest
);
  localparam int unsigned NTF_W = 64;
  localparam int unsigned PAD_W = NTF_W - SRC_W - CODE_W - N_ENT - CNT_W;

  // Register state
  filt_t [N_ENT-1:0] ent_q, ent_d;
  logic [N_ENT-1:0]  flags_q, flags_d;
  logic              stop_q, stop_d;
  logic              nten_q, nten_d;
  logic [1:0]        cap_q, cap_d;
  logic [DEST_W-1:0] dest_q, dest_d;

  // Datapath
  logic [N_ENT-1:0] hit, hv;
  logic [N_ENT-1:0] m_cnt, m_flag, m_ntf, m_stop;
  logic             accept, ctrl_wr, fclr, cclr;
  logic             act_cnt, ent_stop, ent_ntf;
  logic [N_ENT-1:0] flag_set;
  logic             all_trip, thr_trip, hw_stop, ntf_req;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             reach;
  logic [NTF_W-1:0] ntf_word;

  fault_mgr_match u_match (
    .ent  (ent_q),
    .src  (ev_src),
    .code (ev_code),
    .hit  (hit)
  );

  for (genvar g = 0; g < N_ENT; g++) begin : g_mask
    assign m_cnt[g]  = ent_q[g].count;
    assign m_flag[g] = ent_q[g].flag;
    assign m_ntf[g]  = ent_q[g].notify;
    assign m_stop[g] = ent_q[g].stop;
  end

  always_comb begin
    accept   = ev_valid && !stop_q;
    hv       = accept ? hit : '0;
    ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
    fclr     = ctrl_wr && reg_wdata[C_FCLR];
    cclr     = ctrl_wr && reg_wdata[C_CCLR];
    act_cnt  = |(hv & m_cnt);
    flag_set = hv & m_flag;
    ent_stop = |(hv & m_stop);
    ent_ntf  = |(hv & m_ntf);
  end

  fault_mgr_cnt #(
    .CNT_W  (CNT_W),
    .THRESH (THRESH)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (act_cnt),
    .clr     (cclr),
    .cnt     (cnt),
    .cnt_nxt (cnt_nxt),
    .reach   (reach)
  );

  // Next state: flags, halt, control, capability, destination, entries
  always_comb begin
    flags_d  = fclr ? '0 : (flags_q | flag_set);
    all_trip = cap_q[0] && !fclr && (|flag_set) && (&(flags_q | flag_set));
    thr_trip = cap_q[1] && reach;
    hw_stop  = ent_stop || all_trip || thr_trip;
    stop_d   = (ctrl_wr ? reg_wdata[C_STOP] : stop_q) || hw_stop;
    nten_d   = ctrl_wr ? reg_wdata[C_NTEN] : nten_q;
    cap_d    = (reg_wr && reg_addr == A_CAP) ? reg_wdata[1:0] : cap_q;
    dest_d   = (reg_wr && reg_addr == A_DEST) ? reg_wdata[DEST_W-1:0] : dest_q;
    ntf_req  = nten_q && (ent_ntf || all_trip || thr_trip);
    ntf_word = {ev_src, ev_code, flags_d, cnt_nxt, {PAD_W{1'b0}}};
    for (int i = 0; i < N_ENT; i++) begin
      ent_d[i] = (reg_wr && reg_addr == ADDR_W'(i)) ? filt_t'(reg_wdata[FILT_W-1:0])
                                                    : ent_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q   <= '0;
      flags_q <= '0;
      stop_q  <= 1'b0;
      nten_q  <= 1'b0;
      cap_q   <= '0;
      dest_q  <= '0;
    end else begin
      ent_q   <= ent_d;
      flags_q <= flags_d;
      stop_q  <= stop_d;
      nten_q  <= nten_d;
      cap_q   <= cap_d;
      dest_q  <= dest_d;
    end
  end

  fault_mgr_ntf #(.W(NTF_W)) u_ntf (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ntf_req),
    .word  (ntf_word),
    .ready (ntf_ready),
    .valid (ntf_valid),
    .data  (ntf_data)
  );

  assign ntf_dest = dest_q;

  // Read mux
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (reg_addr == ADDR_W'(i)) reg_rdata = DATA_W'(ent_q[i]);
    end
    case (reg_addr)
      A_CTRL:  reg_rdata = DATA_W'({nten_q, stop_q, 2'b00});
      A_CAP:   reg_rdata = DATA_W'(cap_q);
      A_DEST:  reg_rdata = DATA_W'(dest_q);
      A_FLAGS: reg_rdata = DATA_W'(flags_q);
      A_CNT:   reg_rdata = DATA_W'(cnt);
      default: ;
    endcase
  end
endmodule

// File: rtl/fault_mgr_checker.sv
module fault_mgr_checker
  import fault_mgr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              stop_q,
  input logic [N_ENT-1:0]  flags_q,
  input logic [CNT_W-1:0]  cnt,
  input logic              ntf_valid,
  input logic              ntf_ready,
  input logic [63:0]       ntf_data
);
  localparam int unsigned PAD_W = 64 - SRC_W - CODE_W - N_ENT - CNT_W;
  localparam logic [CNT_W-1:0] MAXV = '1;

  p_sat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXV) && !(reg_wr && reg_addr == A_CTRL) |=> (cnt == MAXV));

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> (cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) + 1'b1)));

  p_flags_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  p_halt_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q && !reg_wr |=> stop_q);

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q && !reg_wr |=> $stable(flags_q) && $stable(cnt) && !$rose(ntf_valid));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid && !ntf_ready |=> ntf_valid && $stable(ntf_data));

  p_pad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> (ntf_data[PAD_W-1:0] == '0));
endmodule

bind fault_mgr fault_mgr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .stop_q    (stop_q),
  .flags_q   (flags_q),
  .cnt       (cnt),
  .ntf_valid (ntf_valid),
  .ntf_ready (ntf_ready),
  .ntf_data  (ntf_data)
);

// File: tb/fault_mgr_bench.sv
`timescale 1ns/1ps
module fault_mgr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [5:0]  ev_src = '0;
  logic [7:0]  ev_code = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ntf_valid;
  logic        ntf_ready = 1'b0;
  logic [63:0] ntf_data;
  logic [15:0] ntf_dest;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fault_mgr u_fault_mgr (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_src(ev_src), .ev_code(ev_code),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_data(ntf_data), .ntf_dest(ntf_dest)
  );

  localparam logic [3:0] CTRL = 4'd8, CAP = 4'd9, DEST = 4'd10, FLG = 4'd11, CNT = 4'd12;

  function automatic logic [31:0] fent(input logic [5:0] s, input logic [7:0] c,
                                       input logic cn, input logic fl,
                                       input logic nt, input logic st);
    return {13'b0, st, nt, fl, cn, 1'b1, c, s};
  endfunction

  function automatic logic [63:0] word(input logic [5:0] s, input logic [7:0] c,
                                       input logic [7:0] f, input logic [15:0] n);
    return {s, c, f, n, 26'b0};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic ev(input logic [5:0] s, input logic [7:0] c);
    @(negedge clk);
    ev_valid = 1'b1; ev_src = s; ev_code = c;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic accept_ntf();
    @(negedge clk);
    ntf_ready = 1'b1;
    @(negedge clk);
    ntf_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R9 reset valid", 64'(ntf_valid), 64'd0);
    rd(FLG, d);  chk("R11 reset flags", 64'(d), 64'd0);
    rd(CNT, d);  chk("R1 reset counter", 64'(d), 64'd0);
    rd(CTRL, d); chk("R4 reset ctrl", 64'(d), 64'd0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    wr(4'd0, fent(6'd5, 8'h11, 1, 0, 0, 0));
    repeat (3) ev(6'd5, 8'h11);
    rd(CNT, d); chk("R1 three matches", 64'(d), 64'd3);
    ev(6'd5, 8'h12); ev(6'd6, 8'h11);
    rd(CNT, d); chk("R1 non-match ignored", 64'(d), 64'd3);
    wr(4'd0, 32'd0);
    ev(6'd5, 8'h11);
    rd(CNT, d); chk("R1 disabled entry ignored", 64'(d), 64'd3);
    wr(4'd0, fent(6'd5, 8'h11, 1, 0, 0, 0));
  endtask

  task automatic t_notify();
    logic [31:0] d;
    wr(DEST, 32'h0000BEEF);
    wr(CTRL, 32'h8);
    wr(4'd1, fent(6'd2, 8'h40, 0, 1, 1, 0));
    ev(6'd2, 8'h40);
    chk("R9 valid after notify match", 64'(ntf_valid), 64'd1);
    chk("R9 payload", ntf_data, word(6'd2, 8'h40, 8'h02, 16'd3));
    chk("R9 destination", 64'(ntf_dest), 64'hBEEF);
    rd(FLG, d); chk("R11 flag bit 1", 64'(d), 64'h02);
    repeat (3) @(negedge clk);
    chk("R10 held valid", 64'(ntf_valid), 64'd1);
    ev(6'd5, 8'h11);
    chk("R9 count-only match adds no word", ntf_data, word(6'd2, 8'h40, 8'h02, 16'd3));
    wr(4'd2, fent(6'd3, 8'h41, 0, 1, 1, 0));
    ev(6'd3, 8'h41);
    chk("R10 pending word kept", ntf_data, word(6'd2, 8'h40, 8'h02, 16'd3));
    rd(FLG, d); chk("R10 flags still update", 64'(d), 64'h06);
    rd(CNT, d); chk("R10 counter still updates", 64'(d), 64'd4);
    accept_ntf();
    chk("R10 released after ready", 64'(ntf_valid), 64'd0);
    wr(CTRL, 32'h0);
    ev(6'd3, 8'h41);
    chk("R9 no word when disabled", 64'(ntf_valid), 64'd0);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(CTRL, 32'h3);
    rd(FLG, d);  chk("R3 flags cleared", 64'(d), 64'd0);
    rd(CNT, d);  chk("R3 counter cleared", 64'(d), 64'd0);
    rd(CTRL, d); chk("R3 clear bits read 0", 64'(d), 64'd0);
    @(negedge clk);
    ev_valid = 1'b1; ev_src = 6'd5; ev_code = 8'h11;
    reg_wr = 1'b1; reg_addr = CTRL; reg_wdata = 32'h2;
    @(negedge clk);
    ev_valid = 1'b0; reg_wr = 1'b0;
    rd(CNT, d); chk("R3 clear beats increment", 64'(d), 64'd0);
  endtask

  task automatic t_swstop();
    logic [31:0] d;
    wr(CTRL, 32'h4);
    rd(CTRL, d); chk("R4 halt bit set", 64'(d), 64'h4);
    ev(6'd5, 8'h11); ev(6'd2, 8'h40);
    rd(CNT, d); chk("R6 counter frozen", 64'(d), 64'd0);
    rd(FLG, d); chk("R6 flags frozen", 64'(d), 64'd0);
    repeat (5) @(negedge clk);
    rd(CTRL, d); chk("R4 halt persists", 64'(d), 64'h4);
    wr(CTRL, 32'h0);
    ev(6'd5, 8'h11);
    rd(CNT, d); chk("R4 resumes after write 0", 64'(d), 64'd1);
  endtask

  task automatic t_entstop();
    logic [31:0] d;
    wr(4'd3, fent(6'd7, 8'h77, 0, 0, 0, 1));
    ev(6'd7, 8'h77);
    rd(CTRL, d); chk("R5 entry sets halt", 64'(d), 64'h4);
    ev(6'd5, 8'h11);
    rd(CNT, d); chk("R6 dropped after entry halt", 64'(d), 64'd1);
    wr(CTRL, 32'h0);
  endtask

  task automatic t_allflags();
    logic [31:0] d;
    wr(CTRL, 32'hB);
    for (int i = 0; i < 8; i++) wr(4'(i), fent(6'(i + 10), 8'(8'h80 + i), 0, 1, 0, 0));
    wr(CAP, 32'h1);
    for (int i = 0; i < 7; i++) ev(6'(i + 10), 8'(8'h80 + i));
    rd(CTRL, d); chk("R7 no halt at 7 flags", 64'(d), 64'h8);
    chk("R7 no word yet", 64'(ntf_valid), 64'd0);
    ev(6'd17, 8'h87);
    rd(CTRL, d); chk("R7 halt on all flags", 64'(d), 64'hC);
    chk("R7 word on all flags", ntf_data, word(6'd17, 8'h87, 8'hFF, 16'd0));
    chk("R7 valid", 64'(ntf_valid), 64'd1);
    accept_ntf();
    wr(CAP, 32'h0);
    wr(CTRL, 32'hB);
  endtask

  task automatic t_thresh();
    logic [31:0] d;
    wr(4'd0, fent(6'd5, 8'h11, 1, 0, 0, 0));
    wr(CAP, 32'h2);
    repeat (254) ev(6'd5, 8'h11);
    rd(CNT, d);  chk("R8 counter 254", 64'(d), 64'd254);
    rd(CTRL, d); chk("R8 no halt below threshold", 64'(d), 64'h8);
    ev(6'd5, 8'h11);
    rd(CTRL, d); chk("R8 halt at threshold", 64'(d), 64'hC);
    chk("R8 word at threshold", ntf_data, word(6'd5, 8'h11, 8'h00, 16'h00FF));
    accept_ntf();
    wr(CAP, 32'h0);
    wr(CTRL, 32'h0);
  endtask

  task automatic t_sat();
    logic [31:0] d;
    wr(CTRL, 32'h2);
    @(negedge clk);
    ev_valid = 1'b1; ev_src = 6'd5; ev_code = 8'h11;
    repeat (65538) @(negedge clk);
    ev_valid = 1'b0;
    rd(CNT, d); chk("R2 saturated", 64'(d), 64'hFFFF);
    ev(6'd5, 8'h11);
    rd(CNT, d); chk("R2 holds at max", 64'(d), 64'hFFFF);
    wr(CTRL, 32'h2);
    rd(CNT, d); chk("R3 clear from max", 64'(d), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_notify();
    t_clear();
    t_swstop();
    t_entstop();
    t_allflags();
    t_thresh();
    t_sat();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4ns * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule